// File: doc/BRIEF.md
# Timer Software Event Generator

A compact timer core with a counter of up to 16 bits. The counter runs up, down or center-aligned. A prescaler sets its tick rate, and an auto-reload value bounds its range. Both the prescaler and the auto-reload value are double-buffered: software writes a preload copy, and an update event moves that copy into the active copy. The core also has one capture/compare channel. Its enable, complementary-enable and compare-mode control bits are shadowed, and a commutation event copies them into the active set.

Besides its natural counting events, the block has an event-injection register. Software writes a 1 into one of its bits to fire that event at once:

- an update event,
- a channel capture/compare event,
- a commutation event,
- a break event.

The register holds nothing and always reads as zero. Each injected event has side effects that depend on the current mode. The counter is cleared or reloaded according to the counting direction. In input mode the channel captures the counter value, with overcapture detection. The shadow control bits are transferred to the active set. A break forces the master output enable off.

Each status flag is sticky and drives an interrupt output and a DMA request output through its own enable bit. Software reaches the block through a single-cycle register write port and a combinational read port.

Top module: `timer_evgen`

Register addresses and fields used below:

| Addr | Register | Bits |
|---|---|---|
| 0 | control | [0] run, [2:1] mode (0 up, 1 down, 2 or 3 center), [3] shadow select, [4] output enable |
| 1 | enables | [0] update irq, [1] channel irq, [2] break irq, [3] update DMA, [4] channel DMA, [5] break DMA |
| 2 | flags | [0] update, [1] channel, [2] break, [3] overcapture |
| 3 | events | [0] update, [1] channel, [2] commutation, [3] break |
| 4 | prescaler preload | |
| 5 | reload preload | |
| 6 | capture/compare value | |
| 7 | channel config | [0] input mode, [1] shadow enable, [2] shadow complementary enable, [4:3] shadow compare mode; read-only active copy in [8] enable, [9] complementary enable, [11:10] compare mode |
| 8 | counter | |
| 9 | active prescaler | read-only |
| 10 | active reload | read-only |

## Requirements
- R1: After reset the following hold:
  - the counter, the flags, the enables, the output enable and all interrupt/DMA outputs are 0;
  - the active prescaler is 0;
  - the active and preload reload values are all ones.
- R2: The events register (address 3) always reads 0. Writing 0 to a bit of it, or writing its reserved bits [15:4], changes no counter, flag or output.
- R3: An injected update event in up or center mode clears the counter and the prescaler counter in the same cycle. After the event the next counter increment comes exactly prescaler+1 cycles later.
- R4: An injected update event in down mode loads the counter with the reload value in effect after the event. That value is the preload copy if update irq enable is set, and the active copy otherwise.
- R5: An injected update event sets the update flag. It copies the prescaler and reload preloads into the active copies only when update irq enable (enables bit 0) is 1.
- R6: Each interrupt output bit i (0 update, 1 channel, 2 break) equals flag i AND enables bit i. Each DMA output bit i equals flag i AND enables bit i+3. An injected channel event sets the channel flag.
- R7: An injected channel event with the channel in input mode captures the current counter value into the capture/compare value. In output mode the capture/compare value is left unchanged.
- R8: A capture sets the overcapture flag when the channel flag was already 1 before it.
- R9: With shadow select 0, an injected commutation event copies the shadow channel bits to the active channel outputs, and the trigger input is ignored.
- R10: With shadow select 1, an injected commutation event is ignored, and a high trigger input in a cycle copies the shadow bits to the active set.
- R11: An injected break event clears the output enable and sets the break flag.
- R12: Flags are sticky. Writing the flags register clears each flag whose written bit is 0 and keeps each flag whose written bit is 1.
- R13: In up mode with run set, the counter wraps from the active reload value to 0. On the wrap it sets the update flag and loads the preloads into the active copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr |
| com_trig_i | input | 1 | External commutation trigger |
| irq_o | output | 3 | Interrupt requests: update, channel, break |
| dma_o | output | 3 | DMA requests: update, channel, break |
| out_en_o | output | 1 | Master output enable |
| ch_en_o | output | 1 | Active channel enable |
| ch_nen_o | output | 1 | Active complementary enable |
| ch_mode_o | output | 2 | Active compare mode |

## Verification
The bench builds the block with its default widths: a 16-bit counter, a 16-bit prescaler and a 16-bit bus. Because the reload and prescaler values are programmed at run time, it uses small values for them: a reload of 3 and a prescaler of 3. With those values a natural wrap and a prescaler phase can be reached within a handful of cycles. The counter is stopped for the event vectors, so the captured values and the reload-by-direction results are exact. The vector table covers all three counting modes, with the update irq enable both clear and set.

// File: rtl/timer_evgen.sv
module timer_evgen #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          com_trig_i,
  output logic [2:0]    irq_o,
  output logic [2:0]    dma_o,
  output logic          out_en_o,
  output logic          ch_en_o,
  output logic          ch_nen_o,
  output logic [1:0]    ch_mode_o
);
  localparam logic [3:0] A_CTRL = 4'd0, A_IEN = 4'd1, A_FLG = 4'd2, A_EV = 4'd3,
                         A_PSC = 4'd4, A_ARR = 4'd5, A_CCV = 4'd6, A_CHC = 4'd7,
                         A_CNT = 4'd8, A_PSCA = 4'd9, A_ARRA = 4'd10;
  localparam logic [1:0] M_UP = 2'd0, M_DN = 2'd1;

  logic          run, sh_sel, oe, dir_dn, ch_in, dir_nat;
  logic [1:0]    mode;
  logic [5:0]    ien;
  logic [3:0]    flg;
  logic [3:0]    sh, act;
  logic [PW-1:0] psc_pre, psc_act, pcnt;
  logic [CW-1:0] arr_pre, arr_act, cnt, ccv, cnt_nat, arr_eff;

  wire we_ev  = bus_we && bus_addr == A_EV;
  wire ev_upd = we_ev && bus_wdata[0];
  wire ev_ch  = we_ev && bus_wdata[1];
  wire ev_com = we_ev && bus_wdata[2];
  wire ev_brk = we_ev && bus_wdata[3];
  wire tick   = run && pcnt == psc_act;
  wire com_go = sh_sel ? com_trig_i : ev_com;
  wire top    = cnt == arr_act;
  wire bot    = cnt == '0;
  wire nat_upd = tick && ((mode == M_UP) ? top :
                          (mode == M_DN) ? bot :
                          (dir_dn ? bot : top));
  wire ld     = nat_upd || (ev_upd && ien[0]);

  assign arr_eff = ld ? arr_pre : arr_act;

  always_comb begin
    cnt_nat = cnt + 1'b1;
    dir_nat = dir_dn;
    case (mode)
      M_UP: if (top) cnt_nat = '0;
      M_DN: cnt_nat = bot ? arr_act : cnt - 1'b1;
      default:
        if (arr_act == '0) cnt_nat = '0;
        else if (!dir_dn) begin
          if (top) begin cnt_nat = cnt - 1'b1; dir_nat = 1'b1; end
        end else if (bot) dir_nat = 1'b0;
        else cnt_nat = cnt - 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; mode <= M_UP; sh_sel <= 1'b0; oe <= 1'b0; dir_dn <= 1'b0;
      ien <= '0; flg <= '0; sh <= '0; act <= '0; ch_in <= 1'b0;
      psc_pre <= '0; psc_act <= '0; pcnt <= '0;
      arr_pre <= '1; arr_act <= '1; cnt <= '0; ccv <= '0;
    end else begin
      if (ev_upd || tick) pcnt <= '0;
      else if (run)       pcnt <= pcnt + 1'b1;
      if (ld) begin psc_act <= psc_pre; arr_act <= arr_pre; end
      if (tick) begin cnt <= cnt_nat; dir_dn <= dir_nat; end
      if (bus_we) begin
        case (bus_addr)
          A_CTRL: begin
            run <= bus_wdata[0]; mode <= bus_wdata[2:1];
            sh_sel <= bus_wdata[3]; oe <= bus_wdata[4];
          end
          A_IEN: ien <= bus_wdata[5:0];
          A_FLG: flg <= flg & bus_wdata[3:0];
          A_PSC: psc_pre <= bus_wdata[PW-1:0];
          A_ARR: arr_pre <= bus_wdata[CW-1:0];
          A_CCV: ccv <= bus_wdata[CW-1:0];
          A_CHC: begin ch_in <= bus_wdata[0]; sh <= bus_wdata[4:1]; end
          A_CNT: cnt <= bus_wdata[CW-1:0];
          default: ;
        endcase
      end
      if (nat_upd || ev_upd) flg[0] <= 1'b1;
      if (ev_upd) begin
        cnt <= (mode == M_DN) ? arr_eff : '0;
        dir_dn <= 1'b0;
      end
      if (ev_ch) begin
        flg[1] <= 1'b1;
        if (ch_in) begin
          ccv <= cnt;
          if (flg[1]) flg[3] <= 1'b1;
        end
      end
      if (ev_brk) begin oe <= 1'b0; flg[2] <= 1'b1; end
      if (com_go) act <= sh;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = DW'({oe, sh_sel, mode, run});
      A_IEN:  bus_rdata = DW'(ien);
      A_FLG:  bus_rdata = DW'(flg);
      A_PSC:  bus_rdata = DW'(psc_pre);
      A_ARR:  bus_rdata = DW'(arr_pre);
      A_CCV:  bus_rdata = DW'(ccv);
      A_CHC:  bus_rdata = DW'({act, 3'b000, sh, ch_in});
      A_CNT:  bus_rdata = DW'(cnt);
      A_PSCA: bus_rdata = DW'(psc_act);
      A_ARRA: bus_rdata = DW'(arr_act);
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o     = flg[2:0] & ien[2:0];
  assign dma_o     = flg[2:0] & ien[5:3];
  assign out_en_o  = oe;
  assign ch_en_o   = act[0];
  assign ch_nen_o  = act[1];
  assign ch_mode_o = act[3:2];

  a_r3_upd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_upd && mode != M_DN) |=> (cnt == '0 && pcnt == '0));
  a_r4_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_upd && mode == M_DN) |=> cnt == $past(ien[0] ? arr_pre : arr_act));
  a_r7_no_capture_out: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ch && !ch_in) |=> $stable(ccv));
  a_r8_overcapture: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ch && ch_in && flg[1]) |=> flg[3]);
  a_r10_sw_com_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_sel && !com_trig_i) |=> $stable(act));
  a_r11_break_kills_oe: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk |=> (!out_en_o && flg[2]));
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[1] && !(bus_we && bus_addr == A_FLG)) |=> flg[1]);
endmodule

// File: tb/timer_evgen_tb.sv
module timer_evgen_tb;
  logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, com_trig_i = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [2:0]  irq_o, dma_o;
  logic        out_en_o, ch_en_o, ch_nen_o;
  logic [1:0]  ch_mode_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  timer_evgen u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .com_trig_i(com_trig_i),
    .irq_o(irq_o), .dma_o(dma_o), .out_en_o(out_en_o), .ch_en_o(ch_en_o),
    .ch_nen_o(ch_nen_o), .ch_mode_o(ch_mode_o));

  // mode[2], upd_ie[1], preset[16], expected counter[16], expected active reload[16]
  localparam logic [50:0] VEC [4] = '{
    {2'd0, 1'b0, 16'h0055, 16'h0000, 16'h0100},
    {2'd2, 1'b1, 16'h00AA, 16'h0000, 16'h0200},
    {2'd1, 1'b0, 16'h0003, 16'h0100, 16'h0100},
    {2'd1, 1'b1, 16'h0003, 16'h0200, 16'h0200}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic trig_pulse();
    @(negedge clk); com_trig_i = 1'b1;
    @(negedge clk); com_trig_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd8, v);  chk("R1 counter", v, 16'h0000);
    rd(4'd2, v);  chk("R1 flags", v, 16'h0000);
    rd(4'd10, v); chk("R1 active reload", v, 16'hFFFF);
    rd(4'd5, v);  chk("R1 reload preload", v, 16'hFFFF);
    rd(4'd9, v);  chk("R1 active prescaler", v, 16'h0000);
    chk("R1 outputs", {10'd0, irq_o, dma_o}, 16'h0000);
    chk("R1 out_en", {15'd0, out_en_o}, 16'h0000);

    // R3/R4/R5 injected update across modes, counter stopped
    for (int i = 0; i < 4; i++) begin
      wr(4'd5, 16'h0100); wr(4'd1, 16'h0001); wr(4'd3, 16'h0001);
      wr(4'd5, 16'h0200); wr(4'd1, {15'd0, VEC[i][48]});
      wr(4'd0, {13'd0, VEC[i][50:49], 1'b0});
      wr(4'd8, VEC[i][47:32]); wr(4'd2, 16'h0000); wr(4'd3, 16'h0001);
      rd(4'd8, v);  chk("R3/R4 counter after update", v, VEC[i][31:16]);
      rd(4'd10, v); chk("R5 active reload after update", v, VEC[i][15:0]);
      rd(4'd2, v);  chk("R5 update flag", v, 16'h0001);
    end

    // R3 prescaler counter cleared by injected update
    wr(4'd0, 16'h0000); wr(4'd4, 16'h0003); wr(4'd1, 16'h0001); wr(4'd3, 16'h0001);
    wr(4'd0, 16'h0001);
    repeat (2) @(posedge clk);
    wr(4'd3, 16'h0001);
    repeat (3) @(posedge clk);
    @(negedge clk); rd(4'd8, v); chk("R3 no tick before prescale", v, 16'h0000);
    @(posedge clk);
    @(negedge clk); rd(4'd8, v); chk("R3 tick after prescale", v, 16'h0001);
    wr(4'd0, 16'h0000); wr(4'd4, 16'h0000); wr(4'd3, 16'h0001);

    // R13 natural wrap in up mode
    wr(4'd5, 16'h0003); wr(4'd3, 16'h0001); wr(4'd5, 16'h0005); wr(4'd2, 16'h0000);
    wr(4'd0, 16'h0001);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(4'd8, v); chk("R13 counter at reload", v, 16'h0003);
    rd(4'd2, v); chk("R13 no flag before wrap", v, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    rd(4'd8, v);  chk("R13 wrap to zero", v, 16'h0000);
    rd(4'd2, v);  chk("R13 update flag on wrap", v, 16'h0001);
    rd(4'd10, v); chk("R13 preload moved on wrap", v, 16'h0005);
    chk("R6 update irq", {13'd0, irq_o}, 16'h0001);
    wr(4'd0, 16'h0000);

    // R6/R7/R8 channel events
    wr(4'd1, 16'h0002); wr(4'd7, 16'h0001); wr(4'd8, 16'h1234); wr(4'd2, 16'h0000);
    wr(4'd3, 16'h0002);
    rd(4'd6, v); chk("R7 capture", v, 16'h1234);
    rd(4'd2, v); chk("R6/R8 channel flag only", v, 16'h0002);
    chk("R6 channel irq", {13'd0, irq_o}, 16'h0002);
    chk("R6 dma off", {13'd0, dma_o}, 16'h0000);
    wr(4'd8, 16'h2222); wr(4'd3, 16'h0002);
    rd(4'd6, v); chk("R7 second capture", v, 16'h2222);
    rd(4'd2, v); chk("R8 overcapture", v, 16'h000A);
    wr(4'd1, 16'h0012);
    chk("R6 channel dma", {13'd0, dma_o}, 16'h0002);
    wr(4'd7, 16'h0000); wr(4'd6, 16'h0011); wr(4'd3, 16'h0002);
    rd(4'd6, v); chk("R7 output mode no capture", v, 16'h0011);

    // R9 software commutation
    wr(4'd0, 16'h0000); wr(4'd7, 16'h0012);
    chk("R9 before commutation", {12'd0, ch_mode_o, ch_nen_o, ch_en_o}, 16'h0000);
    trig_pulse();
    chk("R9 trigger ignored", {12'd0, ch_mode_o, ch_nen_o, ch_en_o}, 16'h0000);
    wr(4'd3, 16'h0004);
    chk("R9 commutation copies", {12'd0, ch_mode_o, ch_nen_o, ch_en_o}, 16'h0009);

    // R10 trigger commutation
    wr(4'd0, 16'h0008); wr(4'd7, 16'h000C); wr(4'd3, 16'h0004);
    chk("R10 sw command ignored", {12'd0, ch_mode_o, ch_nen_o, ch_en_o}, 16'h0009);
    trig_pulse();
    chk("R10 trigger copies", {12'd0, ch_mode_o, ch_nen_o, ch_en_o}, 16'h0006);

    // R11 break
    wr(4'd0, 16'h0010);
    chk("R11 oe set", {15'd0, out_en_o}, 16'h0001);
    wr(4'd1, 16'h0004); wr(4'd3, 16'h0008);
    chk("R11 oe cleared", {15'd0, out_en_o}, 16'h0000);
    rd(4'd2, v); chk("R11 break flag", {15'd0, v[2]}, 16'h0001);
    chk("R11 break irq", {13'd0, irq_o}, 16'h0004);

    // R2 zero and reserved writes have no effect
    wr(4'd0, 16'h0010); wr(4'd8, 16'h0007); wr(4'd2, 16'h0000);
    wr(4'd3, 16'hFFF0); wr(4'd3, 16'h0000);
    rd(4'd8, v); chk("R2 counter untouched", v, 16'h0007);
    rd(4'd2, v); chk("R2 flags untouched", v, 16'h0000);
    chk("R2 oe untouched", {15'd0, out_en_o}, 16'h0001);
    rd(4'd3, v); chk("R2 events read zero", v, 16'h0000);

    // R12 sticky flags
    wr(4'd3, 16'h0002); wr(4'd3, 16'h0008);
    rd(4'd2, v); chk("R12 flags set", v, 16'h0006);
    wr(4'd2, 16'hFFFB);
    rd(4'd2, v); chk("R12 selective clear", v, 16'h0002);
    wr(4'd2, 16'hFFFF);
    rd(4'd2, v); chk("R12 ones keep", v, 16'h0002);

    finish_run();
  end
endmodule